// File: doc/BRIEF.md
# Serial Link Frame Synchronizer

This block sits on one serial input link, directly behind an 8b/10b deserializer that has already recovered 32-bit words. Each incoming word arrives with a flag telling whether it is ordinary data or a control (K) word. Any K word is treated as a fill character. Payload travels in frames of exactly seven data words, each word holding three timeslice samples. The synchronizer locates frame boundaries from the fill characters, forwards data words with a word index and a frame-start marker, and checks that the stream keeps to the framing rules.

After the deserializer reports lock, nothing is forwarded until a fill character has been seen. From then on frames may follow each other with no fill between them. A fill that lands inside a frame is a framing violation: lock is dropped and the block hunts for the next fill. Independently, the block flags a stream that goes more than a set number of data words without any fill, and it flags every loss of deserializer lock. These three conditions are held in sticky flags until a clear pulse or reset. A frame-lock status and a data-activity status are also provided.

Top module: `link_frame_sync`

## Requirements
- R1: While not frame-locked (after reset, after deserializer lock is gained, or after a framing violation), data words are discarded: `out_valid` stays low and `frame_locked` stays low until a fill word is received.
- R2: A fill word (`in_valid`=1, `in_is_fill`=1) received while `serdes_locked`=1 and not yet locked sets `frame_locked` in the cycle after that word's clock edge; the fill word itself is never forwarded.
- R3: While locked, each data word (`in_is_fill`=0) appears on `out_word` with `out_valid`=1 one clock after it is sampled; `out_idx` counts 0 to 6 within the frame and `out_sof`=1 exactly when `out_idx`=0.
- R4: Frames may follow one another with no fill between them: after index 6 the next data word carries index 0 with `out_sof`=1 and no error is raised.
- R5: A fill word received at a frame boundary (next index 0) keeps `frame_locked` high and raises no frame error.
- R6: A fill word received when the next index is not 0 sets the sticky `frame_err` and clears `frame_locked` in the cycle after the edge; data words are then discarded until the next fill word re-acquires lock at index 0.
- R7: The count of consecutive data words since the last fill word is tracked while `serdes_locked`=1; when more than 100 such words arrive, `comma_err` is set after the edge of the 101st; exactly 100 does not set it.
- R8: A falling edge of `serdes_locked` sets the sticky `lock_err` and clears `frame_locked` one cycle later.
- R9: `frame_err`, `comma_err` and `lock_err` stay set until a cycle with `clear_errors`=1, after which they read 0 (a new error event in the same cycle takes priority over the clear).
- R10: `data_active` goes high after any edge at which `in_valid`=1 and stays high through the following 3 idle edges, falling after the 4th consecutive idle edge.
- R11: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| serdes_locked | input | 1 | Deserializer lock status |
| in_valid | input | 1 | A word is present this cycle |
| in_word | input | 32 | Received word |
| in_is_fill | input | 1 | 1 = K (fill) word, 0 = data word |
| clear_errors | input | 1 | Clears the sticky error flags |
| out_valid | output | 1 | Forwarded data word valid |
| out_word | output | 32 | Forwarded data word |
| out_idx | output | 3 | Word position in frame, 0 to 6 |
| out_sof | output | 1 | First word of a frame |
| frame_locked | output | 1 | Frame synchronization held |
| data_active | output | 1 | Words recently received |
| frame_err | output | 1 | Sticky: fill inside a frame |
| comma_err | output | 1 | Sticky: too long without fill |
| lock_err | output | 1 | Sticky: deserializer lock lost |

## Verification
Every result here is one register away from the input that causes it: a forwarded word, a lock change and each sticky flag all appear in the cycle after the edge that sampled the word or the lock drop. The bench drives inputs at the falling edge and samples one time unit after the next rising edge, so each check reads exactly the cycle in which its result is due. The comma limit is probed at 100 and 101 words and activity hold at the third and fourth idle edge, both exactly at the boundary cycle.

// File: rtl/lfs_pkg.sv
// Shared types for the link frame synchronizer.
// Assumes: none beyond the defaults below.
package lfs_pkg;
    typedef enum logic {
        FS_HUNT = 1'b0,
        FS_SYNC = 1'b1
    } fs_state_e;

    localparam int ERR_FRAME = 0;
    localparam int ERR_COMMA = 1;
    localparam int ERR_LOCK  = 2;
    localparam int NUM_ERR   = 3;
endpackage

// File: rtl/lfs_framer.sv
// Frame boundary tracker: hunts for a fill word, then counts data words
// modulo FRAME_LEN and forwards them with index and start-of-frame marks.
// Assumes: fills are legal only when the next index is 0.
module lfs_framer
    import lfs_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int FRAME_LEN = 7,
    localparam int IDX_W    = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_is_fill,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_sof,
    output logic              locked,
    output logic              frame_err_evt
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    fs_state_e        state_q;
    logic [IDX_W-1:0] idx_q;
    logic             take_data;

    // Decode this cycle's word against the frame position.
    always_comb begin
        take_data     = link_up && in_valid && !in_is_fill && (state_q == FS_SYNC);
        frame_err_evt = link_up && in_valid && in_is_fill &&
                        (state_q == FS_SYNC) && (idx_q != '0);
    end

    // Lock state and word position within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_HUNT;
            idx_q   <= '0;
        end else if (!link_up) begin
            state_q <= FS_HUNT;
            idx_q   <= '0;
        end else if (in_valid && in_is_fill) begin
            if (state_q == FS_HUNT) begin
                state_q <= FS_SYNC;
                idx_q   <= '0;
            end else if (frame_err_evt) begin
                state_q <= FS_HUNT;
                idx_q   <= '0;
            end
        end else if (take_data) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    // Output register for forwarded data words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_idx   <= '0;
            out_sof   <= 1'b0;
        end else begin
            out_valid <= take_data;
            if (take_data) begin
                out_word <= in_word;
                out_idx  <= idx_q;
                out_sof  <= (idx_q == '0);
            end
        end
    end

    assign locked = (state_q == FS_SYNC);

    AST_NO_OUT_WHILE_HUNTING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_HUNT) |=> !out_valid); // R1
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_idx <= LAST_IDX)); // R3
    AST_MIDFRAME_FILL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_evt |=> !locked); // R6
    AST_LINK_DOWN_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> !locked); // R8
endmodule

// File: rtl/lfs_link_monitor.sv
// Link health watcher: counts data words between fills, detects loss of
// deserializer lock, and stretches word arrivals into an activity status.
// Assumes: GAP_LIMIT >= 1 and ACT_HOLD >= 1.
module lfs_link_monitor #(
    parameter int GAP_LIMIT = 100,
    parameter int ACT_HOLD  = 4,
    localparam int GAP_W    = $clog2(GAP_LIMIT + 1),
    localparam int ACT_W    = $clog2(ACT_HOLD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    input  logic in_valid,
    input  logic in_is_fill,
    output logic comma_err_evt,
    output logic lock_err_evt,
    output logic data_active
);
    localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(GAP_LIMIT);
    localparam logic [ACT_W-1:0] ACT_LOAD = ACT_W'(ACT_HOLD);

    logic [GAP_W-1:0] gap_q;
    logic [ACT_W-1:0] act_q;
    logic             link_prev_q;

    // Events seen this cycle.
    always_comb begin
        comma_err_evt = link_up && in_valid && !in_is_fill && (gap_q == GAP_MAX);
        lock_err_evt  = link_prev_q && !link_up;
    end

    // Consecutive data words since the last fill, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_up) begin
            gap_q <= '0;
        end else if (in_valid) begin
            if (in_is_fill)
                gap_q <= '0;
            else if (gap_q != GAP_MAX)
                gap_q <= gap_q + 1'b1;
        end
    end

    // Previous lock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) link_prev_q <= 1'b0;
        else        link_prev_q <= link_up;
    end

    // Activity hold counter, reloaded by every arriving word.
    always_ff @(posedge clk) begin
        if (!rst_n)             act_q <= '0;
        else if (in_valid)      act_q <= ACT_LOAD;
        else if (act_q != '0)   act_q <= act_q - 1'b1;
    end

    assign data_active = (act_q != '0);

    AST_FILL_CLEARS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && in_valid && in_is_fill) |=> (gap_q == '0)); // R7
    AST_WORD_MAKES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> data_active); // R10
endmodule

// File: rtl/lfs_err_latch.sv
// Sticky error flags: each bit sets on its event and clears on the clear
// strobe; a set in the same cycle wins.
// Assumes: events are single-cycle or level, either is fine.
module lfs_err_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic         clear,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // One sticky bit.
        always_ff @(posedge clk) begin
            if (!rst_n)          flags[g] <= 1'b0;
            else if (set_evt[g]) flags[g] <= 1'b1;
            else if (clear)      flags[g] <= 1'b0;
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !clear) |=> flags[g]); // R9
        AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clear && !set_evt[g]) |=> !flags[g]); // R9
    end
endmodule

// File: rtl/link_frame_sync.sv
// Top of the link frame synchronizer: ties the framer, the link monitor
// and the sticky error flags together.
// Assumes: one word per clock at most, already 8b/10b decoded.
module link_frame_sync
    import lfs_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int FRAME_LEN = 7,
    parameter int GAP_LIMIT = 100,
    parameter int ACT_HOLD  = 4,
    localparam int IDX_W    = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serdes_locked,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_is_fill,
    input  logic              clear_errors,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_sof,
    output logic              frame_locked,
    output logic              data_active,
    output logic              frame_err,
    output logic              comma_err,
    output logic              lock_err
);
    logic               frame_evt;
    logic               comma_evt;
    logic               lock_evt;
    logic [NUM_ERR-1:0] evt_vec;
    logic [NUM_ERR-1:0] flag_vec;

    lfs_framer #(
        .WORD_W    (WORD_W),
        .FRAME_LEN (FRAME_LEN)
    ) u_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .link_up       (serdes_locked),
        .in_valid      (in_valid),
        .in_word       (in_word),
        .in_is_fill    (in_is_fill),
        .out_valid     (out_valid),
        .out_word      (out_word),
        .out_idx       (out_idx),
        .out_sof       (out_sof),
        .locked        (frame_locked),
        .frame_err_evt (frame_evt)
    );

    lfs_link_monitor #(
        .GAP_LIMIT (GAP_LIMIT),
        .ACT_HOLD  (ACT_HOLD)
    ) u_monitor (
        .clk           (clk),
        .rst_n         (rst_n),
        .link_up       (serdes_locked),
        .in_valid      (in_valid),
        .in_is_fill    (in_is_fill),
        .comma_err_evt (comma_evt),
        .lock_err_evt  (lock_evt),
        .data_active   (data_active)
    );

    // Gather the error events into the latch vector.
    always_comb begin
        evt_vec            = '0;
        evt_vec[ERR_FRAME] = frame_evt;
        evt_vec[ERR_COMMA] = comma_evt;
        evt_vec[ERR_LOCK]  = lock_evt;
    end

    lfs_err_latch #(
        .N (NUM_ERR)
    ) u_errs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (evt_vec),
        .clear   (clear_errors),
        .flags   (flag_vec)
    );

    assign frame_err = flag_vec[ERR_FRAME];
    assign comma_err = flag_vec[ERR_COMMA];
    assign lock_err  = flag_vec[ERR_LOCK];

    AST_SOF_MATCHES_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> (out_idx == '0)); // R3
endmodule

// File: tb/link_frame_sync_bench.sv
// Directed bench for link_frame_sync: one task per scenario.
module link_frame_sync_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        serdes_locked = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_is_fill = 1'b0;
    logic        clear_errors = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;
    logic [2:0]  out_idx;
    logic        out_sof;
    logic        frame_locked;
    logic        data_active;
    logic        frame_err;
    logic        comma_err;
    logic        lock_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    link_frame_sync u_link_frame_sync (
        .clk (clk), .rst_n (rst_n), .serdes_locked (serdes_locked),
        .in_valid (in_valid), .in_word (in_word), .in_is_fill (in_is_fill),
        .clear_errors (clear_errors), .out_valid (out_valid),
        .out_word (out_word), .out_idx (out_idx), .out_sof (out_sof),
        .frame_locked (frame_locked), .data_active (data_active),
        .frame_err (frame_err), .comma_err (comma_err), .lock_err (lock_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, sample just after the rising edge.
    task automatic cyc(input bit v, input logic [31:0] w, input bit f, input bit clr);
        @(negedge clk);
        in_valid = v; in_word = w; in_is_fill = f; clear_errors = clr;
        @(posedge clk);
        #1;
    endtask

    task automatic set_link(input bit val);
        @(negedge clk);
        serdes_locked = val; in_valid = 1'b0; in_is_fill = 1'b0; clear_errors = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "out_valid", 32'(out_valid), 0);
        chk("R11", "frame_locked", 32'(frame_locked), 0);
        chk("R11", "data_active", 32'(data_active), 0);
        chk("R11", "errors", {29'd0, frame_err, comma_err, lock_err}, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_hunt();
        set_link(1'b1);
        for (int i = 0; i < 3; i++) begin
            cyc(1, 32'h1111_0000 + i, 0, 0);
            chk("R1", "out_valid in hunt", 32'(out_valid), 0);
            chk("R1", "frame_locked in hunt", 32'(frame_locked), 0);
        end
    endtask

    task automatic t_acquire();
        cyc(1, 32'hFFFF_FFBC, 1, 0);
        chk("R2", "frame_locked after fill", 32'(frame_locked), 1);
        chk("R2", "fill not forwarded", 32'(out_valid), 0);
    endtask

    task automatic send_frame(input string req, input logic [31:0] base);
        for (int i = 0; i < 7; i++) begin
            cyc(1, base + i, 0, 0);
            chk(req, "out_valid", 32'(out_valid), 1);
            chk(req, "out_word", out_word, base + i);
            chk(req, "out_idx", 32'(out_idx), i);
            chk(req, "out_sof", 32'(out_sof), (i == 0) ? 1 : 0);
        end
    endtask

    task automatic t_frames();
        send_frame("R3", 32'hA000_0000);
        send_frame("R4", 32'hB000_0000);
        chk("R4", "no frame_err back-to-back", 32'(frame_err), 0);
    endtask

    task automatic t_fill_between();
        cyc(1, 32'h0000_00BC, 1, 0);
        chk("R5", "lock kept", 32'(frame_locked), 1);
        chk("R5", "no frame_err", 32'(frame_err), 0);
    endtask

    task automatic t_midfill();
        for (int i = 0; i < 3; i++) cyc(1, 32'hC000_0000 + i, 0, 0);
        cyc(1, 32'h0000_00BC, 1, 0);
        chk("R6", "frame_err set", 32'(frame_err), 1);
        chk("R6", "lock dropped", 32'(frame_locked), 0);
        cyc(1, 32'hC000_0010, 0, 0);
        chk("R6", "data dropped after error", 32'(out_valid), 0);
        chk("R6", "frame_err sticky", 32'(frame_err), 1);
        cyc(1, 32'h0000_00BC, 1, 0);
        chk("R6", "relock on fill", 32'(frame_locked), 1);
        cyc(1, 32'hC000_0020, 0, 0);
        chk("R6", "relock idx", 32'(out_idx), 0);
        chk("R6", "relock sof", 32'(out_sof), 1);
    endtask

    task automatic t_clear();
        cyc(0, 0, 0, 1);
        chk("R9", "frame_err cleared", 32'(frame_err), 0);
    endtask

    task automatic t_comma();
        // One data word already counted since the last fill.
        for (int i = 0; i < 99; i++) cyc(1, 32'hD000_0000 + i, 0, 0);
        chk("R7", "comma_err at 100", 32'(comma_err), 0);
        cyc(1, 32'h0000_00BC, 1, 0);
        for (int i = 0; i < 100; i++) cyc(1, 32'hE000_0000 + i, 0, 0);
        chk("R7", "comma_err at 100 again", 32'(comma_err), 0);
        cyc(1, 32'hE000_0100, 0, 0);
        chk("R7", "comma_err at 101", 32'(comma_err), 1);
        cyc(0, 0, 0, 0);
        chk("R9", "comma_err sticky", 32'(comma_err), 1);
        cyc(0, 0, 0, 1);
        chk("R9", "comma_err cleared", 32'(comma_err), 0);
    endtask

    task automatic t_lock_loss();
        cyc(1, 32'h0000_00BC, 1, 0);
        chk("R8", "locked before drop", 32'(frame_locked), 1);
        set_link(1'b0);
        chk("R8", "lock_err set", 32'(lock_err), 1);
        chk("R8", "frame lock dropped", 32'(frame_locked), 0);
        set_link(1'b1);
        chk("R9", "lock_err sticky", 32'(lock_err), 1);
        cyc(0, 0, 0, 1);
        chk("R9", "lock_err cleared", 32'(lock_err), 0);
    endtask

    task automatic t_activity();
        cyc(1, 32'hF000_0000, 0, 0);
        chk("R10", "active after word", 32'(data_active), 1);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
        chk("R10", "active after 3 idle", 32'(data_active), 1);
        cyc(0, 0, 0, 0);
        chk("R10", "inactive after 4 idle", 32'(data_active), 0);
    endtask

    initial begin
        t_reset();
        t_hunt();
        t_acquire();
        t_frames();
        t_fill_between();
        t_midfill();
        t_clear();
        t_comma();
        t_lock_loss();
        t_activity();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule